// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block parses one instruction from a six-byte window of fetched instruction memory. The window holds the bytes at the current program counter and the five bytes after it, with the lowest-addressed byte in the lowest eight bits. The first byte alone fixes the instruction's length of 1, 2, 5 or 6 bytes. The block then picks out the operation and variant nibbles, the two register selectors and a 32-bit little-endian constant, and forms the fall-through address. It also flags any byte pattern that does not form a legal instruction.

The decode logic is a single layer of logic after the window. Its results are captured in one output register stage whenever the window is marked valid, so a fetch unit can present a new window every cycle. Register ID 8 means "no register". Wherever an instruction carries no register operand, both selector outputs read 8.

Top module: `insn_window_decoder`

## Requirements
- R1: One cycle after a valid window, `op_code` equals bits [7:4] of byte 0 and `op_var` equals bits [3:0] of byte 0. Byte k of the window sits at `fetch_bytes[8k+7:8k]`. This holds for legal and illegal instructions alike.
- R2: Operation codes 0x0, 0x1 and 0x9 with variant 0 are one byte long. They give `reg_a` = `reg_b` = 8 and `imm` = 0.
- R3: Operation codes 0x2, 0x6, 0xA and 0xB are two bytes long. `reg_a` is bits [7:4] and `reg_b` is bits [3:0] of byte 1, and `imm` is 0.
- R4: Operation codes 0x3, 0x4 and 0x5 are six bytes long. They take their registers from byte 1 as in R3, and `imm` = {byte5, byte4, byte3, byte2}.
- R5: Operation codes 0x7 and 0x8 are five bytes long. They give `imm` = {byte4, byte3, byte2, byte1} and `reg_a` = `reg_b` = 8.
- R6: Operation 0x6 accepts variants 0 to 3, operation 0x7 accepts variants 0 to 6, and every other known operation accepts only variant 0. Any other variant makes the instruction illegal.
- R7: Register selector checks. A selector that must name a register must be 0 to 7: `reg_a` of 0x2, 0x4, 0x5, 0x6, 0xA and 0xB, and `reg_b` of 0x2, 0x3 and 0x6. A slot that must say "none" must hold exactly 8: `reg_a` of 0x3, and `reg_b` of 0xA and 0xB. The optional base `reg_b` of 0x4 and 0x5 may be 0 to 8. Any other value makes the instruction illegal.
- R8: Operation codes 0xC to 0xF are illegal.
- R9: An illegal instruction gives `illegal` = 1, `insn_len` = 1, `reg_a` = `reg_b` = 8 and `imm` = 0.
- R10: `next_pc` equals `pc` + `insn_len`, modulo 2^32.
- R11: Results appear on the clock edge after `fetch_valid` is high, with `out_valid` = 1. A cycle with `fetch_valid` low gives `out_valid` = 0, and all other outputs keep their values.
- R12: During reset, `out_valid`, `illegal`, `op_code`, `op_var`, `imm`, `insn_len` and `next_pc` are 0, and `reg_a` = `reg_b` = 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Window and pc are valid this cycle |
| pc | input | 32 | Address of byte 0 of the window |
| fetch_bytes | input | 48 | Six fetched bytes, byte 0 in bits [7:0] |
| out_valid | output | 1 | Decoded results updated this cycle |
| op_code | output | 4 | Operation nibble |
| op_var | output | 4 | Variant nibble |
| reg_a | output | 4 | First register selector, 8 when absent |
| reg_b | output | 4 | Second register selector, 8 when absent |
| imm | output | 32 | Little-endian constant, 0 when absent |
| insn_len | output | 3 | Instruction length in bytes |
| next_pc | output | 32 | Fall-through address |
| illegal | output | 1 | Byte pattern is not a legal instruction |

## Verification
The bench probes the constant's byte positions with distinct byte values, so a decoder that reverses byte order or starts the constant one byte off yields a wrong `imm` for the five-byte and six-byte forms. It tests each register slot kind with values just outside its allowed range: 8 where a real register is required, a real register where 8 is required, and 9 in the optional base slot. A decoder that mixes up these slot kinds would either accept these patterns or reject legal ones. It checks the highest legal and lowest illegal variant for the two operations that have variants. It also wraps `next_pc` past the top of the address space, which catches a truncated or sign-confused adder. A decoder that did not force the length to 1 on an illegal pattern would report the nominal length instead.

// File: rtl/insn_window_decoder.sv
module insn_window_decoder #(
  parameter int PC_W  = 32,
  parameter int IMM_W = 32,
  parameter int WIN_B = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_valid,
  input  logic [PC_W-1:0]    pc,
  input  logic [WIN_B*8-1:0] fetch_bytes,
  output logic               out_valid,
  output logic [3:0]         op_code,
  output logic [3:0]         op_var,
  output logic [3:0]         reg_a,
  output logic [3:0]         reg_b,
  output logic [IMM_W-1:0]   imm,
  output logic [2:0]         insn_len,
  output logic [PC_W-1:0]    next_pc,
  output logic               illegal
);

  localparam logic [3:0] NO_REG = 4'h8;

  logic [7:0] b [WIN_B];
  for (genvar k = 0; k < WIN_B; k++) begin : g_bytes
    assign b[k] = fetch_bytes[8*k +: 8];
  end

  wire [3:0] c_op  = b[0][7:4];
  wire [3:0] c_var = b[0][3:0];
  wire [3:0] sel_a = b[1][7:4];
  wire [3:0] sel_b = b[1][3:0];

  logic [2:0] nom_len;
  logic known, var_ok, has_regs, imm_lo, imm_hi;
  logic a_need, a_none, b_need, b_none, b_opt;

  always_comb begin
    nom_len  = 3'd1;
    known    = 1'b1;
    var_ok   = (c_var == 4'h0);
    has_regs = 1'b0;
    imm_lo   = 1'b0;
    imm_hi   = 1'b0;
    a_need   = 1'b0;
    a_none   = 1'b0;
    b_need   = 1'b0;
    b_none   = 1'b0;
    b_opt    = 1'b0;
    case (c_op)
      4'h0, 4'h1, 4'h9: nom_len = 3'd1;
      4'h2: begin nom_len = 3'd2; has_regs = 1'b1; a_need = 1'b1; b_need = 1'b1; end
      4'h3: begin nom_len = 3'd6; has_regs = 1'b1; a_none = 1'b1; b_need = 1'b1; imm_hi = 1'b1; end
      4'h4, 4'h5: begin nom_len = 3'd6; has_regs = 1'b1; a_need = 1'b1; b_opt = 1'b1; imm_hi = 1'b1; end
      4'h6: begin nom_len = 3'd2; has_regs = 1'b1; a_need = 1'b1; b_need = 1'b1; var_ok = (c_var <= 4'h3); end
      4'h7: begin nom_len = 3'd5; imm_lo = 1'b1; var_ok = (c_var <= 4'h6); end
      4'h8: begin nom_len = 3'd5; imm_lo = 1'b1; end
      4'hA, 4'hB: begin nom_len = 3'd2; has_regs = 1'b1; a_need = 1'b1; b_none = 1'b1; end
      default: known = 1'b0;
    endcase
  end

  wire a_ok = a_need ? (sel_a < NO_REG) : a_none ? (sel_a == NO_REG) : 1'b1;
  wire b_ok = b_need ? (sel_b < NO_REG) : b_none ? (sel_b == NO_REG) :
              b_opt  ? (sel_b <= NO_REG) : 1'b1;

  wire        c_bad = !known || !var_ok || (has_regs && !(a_ok && b_ok));
  wire [2:0]  c_len = c_bad ? 3'd1 : nom_len;
  wire [IMM_W-1:0] c_imm = c_bad  ? '0 :
                           imm_hi ? {b[5], b[4], b[3], b[2]} :
                           imm_lo ? {b[4], b[3], b[2], b[1]} : '0;
  wire        use_regs = has_regs && !c_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      op_code   <= '0;
      op_var    <= '0;
      reg_a     <= NO_REG;
      reg_b     <= NO_REG;
      imm       <= '0;
      insn_len  <= '0;
      next_pc   <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= fetch_valid;
      if (fetch_valid) begin
        op_code  <= c_op;
        op_var   <= c_var;
        reg_a    <= use_regs ? sel_a : NO_REG;
        reg_b    <= use_regs ? sel_b : NO_REG;
        imm      <= c_imm;
        insn_len <= c_len;
        next_pc  <= pc + PC_W'(c_len);
        illegal  <= c_bad;
      end
    end
  end

endmodule

// File: rtl/insn_window_decoder_chk.sv
module insn_window_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fetch_valid,
  input logic [31:0] pc,
  input logic [47:0] fetch_bytes,
  input logic        out_valid,
  input logic [3:0]  op_code,
  input logic [3:0]  reg_a,
  input logic [3:0]  reg_b,
  input logic [2:0]  insn_len,
  input logic [31:0] next_pc,
  input logic        illegal
);

  assert_opcode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> op_code == $past(fetch_bytes[7:4]));

  assert_jump_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !illegal && (op_code == 4'h7 || op_code == 4'h8)) |-> insn_len == 3'd5);

  assert_sel_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !illegal) |-> (reg_a <= 4'h8 && reg_b <= 4'h8));

  assert_unknown_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_bytes[7:6] == 2'b11) |=> illegal);

  assert_bad_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> (insn_len == 3'd1 && reg_a == 4'h8 && reg_b == 4'h8));

  assert_next_pc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> next_pc == $past(pc) + {29'b0, insn_len});

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> (!out_valid && $stable(next_pc) && $stable(op_code)));

  assert_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> out_valid);

endmodule

bind insn_window_decoder insn_window_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .pc(pc),
  .fetch_bytes(fetch_bytes), .out_valid(out_valid), .op_code(op_code),
  .reg_a(reg_a), .reg_b(reg_b), .insn_len(insn_len), .next_pc(next_pc),
  .illegal(illegal)
);

// File: tb/tb_insn_window_decoder.sv
module tb_insn_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] pc = '0;
  logic [47:0] fetch_bytes = '0;
  logic        out_valid, illegal;
  logic [3:0]  op_code, op_var, reg_a, reg_b;
  logic [31:0] imm, next_pc;
  logic [2:0]  insn_len;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  insn_window_decoder dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .pc(pc),
    .fetch_bytes(fetch_bytes), .out_valid(out_valid), .op_code(op_code),
    .op_var(op_var), .reg_a(reg_a), .reg_b(reg_b), .imm(imm),
    .insn_len(insn_len), .next_pc(next_pc), .illegal(illegal)
  );

  // {pc, bytes(byte0 low), op, var, ra, rb, imm, len, illegal}
  localparam int NV = 22;
  localparam logic [131:0] VEC [NV] = '{
    {32'h00000100, 48'hAABBCCDDEE00, 4'h0, 4'h0, 4'h8, 4'h8, 32'h0, 3'd1, 1'b0},
    {32'h00000200, 48'h000000000010, 4'h1, 4'h0, 4'h8, 4'h8, 32'h0, 3'd1, 1'b0},
    {32'h00000300, 48'h112233445590, 4'h9, 4'h0, 4'h8, 4'h8, 32'h0, 3'd1, 1'b0},
    {32'h00000400, 48'hFFFFFFFF3620, 4'h2, 4'h0, 4'h3, 4'h6, 32'h0, 3'd2, 1'b0},
    {32'h00000500, 48'h000000000763, 4'h6, 4'h3, 4'h0, 4'h7, 32'h0, 3'd2, 1'b0},
    {32'h00000600, 48'h0000000058A0, 4'hA, 4'h0, 4'h5, 4'h8, 32'h0, 3'd2, 1'b0},
    {32'h00000700, 48'h0000000078B0, 4'hB, 4'h0, 4'h7, 4'h8, 32'h0, 3'd2, 1'b0},
    {32'h00000800, 48'h123456788230, 4'h3, 4'h0, 4'h8, 4'h2, 32'h12345678, 3'd6, 1'b0},
    {32'h00000900, 48'hDEADBEEF1540, 4'h4, 4'h0, 4'h1, 4'h5, 32'hDEADBEEF, 3'd6, 1'b0},
    {32'h00000A00, 48'h000000806850, 4'h5, 4'h0, 4'h6, 4'h8, 32'h00000080, 3'd6, 1'b0},
    {32'hFFFFFFFE, 48'hFF0000100076, 4'h7, 4'h6, 4'h8, 4'h8, 32'h00001000, 3'd5, 1'b0},
    {32'h00000B00, 48'h991122334480, 4'h8, 4'h0, 4'h8, 4'h8, 32'h11223344, 3'd5, 1'b0},
    {32'h00000C00, 48'h000000000164, 4'h6, 4'h4, 4'h8, 4'h8, 32'h0, 3'd1, 1'b1},
    {32'h00000D00, 48'h000000000077, 4'h7, 4'h7, 4'h8, 4'h8, 32'h0, 3'd1, 1'b1},
    {32'h00000E00, 48'h000000000001, 4'h0, 4'h1, 4'h8, 4'h8, 32'h0, 3'd1, 1'b1},
    {32'hFFFFFFFF, 48'h1234567812C0, 4'hC, 4'h0, 4'h8, 4'h8, 32'h0, 3'd1, 1'b1},
    {32'h00000F00, 48'h0000000053A0, 4'hA, 4'h0, 4'h8, 4'h8, 32'h0, 3'd1, 1'b1},
    {32'h00001000, 48'h000000008120, 4'h2, 4'h0, 4'h8, 4'h8, 32'h0, 3'd1, 1'b1},
    {32'h00001100, 48'h000000001230, 4'h3, 4'h0, 4'h8, 4'h8, 32'h0, 3'd1, 1'b1},
    {32'h00001200, 48'h000000001950, 4'h5, 4'h0, 4'h8, 4'h8, 32'h0, 3'd1, 1'b1},
    {32'h00001300, 48'h000000001860, 4'h6, 4'h0, 4'h8, 4'h8, 32'h0, 3'd1, 1'b1},
    {32'h00001400, 48'h000000000081, 4'h8, 4'h1, 4'h8, 4'h8, 32'h0, 3'd1, 1'b1}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1, 2:            return "R2";
      3, 4, 5, 6:         return "R3";
      7, 8, 9:            return "R4";
      10, 11:             return "R5";
      12, 13, 14, 21:     return "R6";
      15:                 return "R8";
      default:            return "R7";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : main
    logic [131:0] v;
    repeat (3) @(negedge clk);
    // R12 reset values
    chk("R12", "out_valid", 32'(out_valid), 32'd0);
    chk("R12", "reg_a", 32'(reg_a), 32'h8);
    chk("R12", "reg_b", 32'(reg_b), 32'h8);
    chk("R12", "insn_len", 32'(insn_len), 32'd0);
    chk("R12", "next_pc", next_pc, 32'd0);
    chk("R12", "illegal", 32'(illegal), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      pc          = v[131:100];
      fetch_bytes = v[99:52];
      fetch_valid = 1'b1;
      @(negedge clk);
      chk("R11", "out_valid", 32'(out_valid), 32'd1);
      chk("R1", "op_code", 32'(op_code), 32'(v[51:48]));
      chk("R1", "op_var", 32'(op_var), 32'(v[47:44]));
      chk(tag_of(i), "reg_a", 32'(reg_a), 32'(v[43:40]));
      chk(tag_of(i), "reg_b", 32'(reg_b), 32'(v[39:36]));
      chk(tag_of(i), "imm", imm, v[35:4]);
      chk(v[0] ? "R9" : tag_of(i), "insn_len", 32'(insn_len), 32'(v[3:1]));
      chk(v[0] ? "R9" : tag_of(i), "illegal", 32'(illegal), 32'(v[0]));
      chk("R10", "next_pc", next_pc, v[131:100] + 32'(v[3:1]));
    end

    // R11 hold: invalid window with a different pattern changes nothing
    fetch_valid = 1'b0;
    pc          = 32'h0000ABCD;
    fetch_bytes = 48'h123456788230;
    @(negedge clk);
    chk("R11", "out_valid low", 32'(out_valid), 32'd0);
    chk("R11", "op_code held", 32'(op_code), 32'h8);
    chk("R11", "op_var held", 32'(op_var), 32'h1);
    chk("R11", "insn_len held", 32'(insn_len), 32'd1);
    chk("R11", "next_pc held", next_pc, 32'h00001401);
    chk("R11", "illegal held", 32'(illegal), 32'd1);

    // R10 wrap on a six-byte form near the top of the address space
    fetch_valid = 1'b1;
    pc          = 32'hFFFFFFFC;
    @(negedge clk);
    chk("R10", "next_pc wrap", next_pc, 32'h00000002);
    chk("R4", "imm", imm, 32'h12345678);

    // R12 asynchronous reset in mid-stream
    #1 rst_n = 1'b0;
    #0.5;
    chk("R12", "out_valid async", 32'(out_valid), 32'd0);
    chk("R12", "imm async", imm, 32'd0);
    chk("R12", "reg_b async", 32'(reg_b), 32'h8);
    fetch_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule